// File: doc/BRIEF.md
# Two-Lane Serial Converter Data Link

This block sits between a converter front end and a digital modem device, and it moves sample words across a pair of two-bit serial buses, one for each direction. The block runs from a single bit clock. A one-cycle frame strobe marks word boundaries, and a frame is eight bit-clock cycles long. On the receive side, the 12-bit ADC sample and its two overrange strobes pass through a fixed alignment chain. At each frame strobe the block builds a 16-bit word from them and loads it into two byte-wide shift registers. These registers then drive the two receive lanes, most significant bit first.

On the transmit side, two byte-wide shift registers collect one bit per lane on every bit-clock edge. At each frame strobe the block copies the upper 14 bits of the completed 16-bit word into a holding register that feeds the DAC. The DAC input therefore never shows a partly shifted code. When the ADC reports an overrange, the block does not use a separate flag. It replaces the receive word with a full-scale saturation code.

Top module: `conv_serial_link`

## Requirements
- R1: While `rst_n` is low, the outputs `rx_lane` and `dac_code` are zero. This holds from the moment reset is asserted, without waiting for a clock. After reset is released, both outputs stay zero until a frame strobe loads new data.
- R2: With neither clip strobe set, the receive word is the ADC sample left-justified: {adc_data, 4'b0000}.
- R3: With `adc_clip_pos` set, the receive word is 16'h7FFF.
- R4: With only `adc_clip_neg` set, the receive word is 16'h8000.
- R5: With both clip strobes set, the positive code 16'h7FFF is sent.
- R6: `rx_lane[1]` carries the upper byte of the receive word and `rx_lane[0]` the lower byte, MSB first. Bit 7 of each byte appears after the clock edge at which `frm` is high. The remaining bits follow, one per cycle.
- R7: The word loaded at a frame edge is built from the ADC inputs captured exactly 4 clock edges earlier. Inputs captured 3 edges or fewer before the frame edge, and inputs captured 5 or more edges before it, do not take part.
- R8: The bits on `tx_lane` at the `frm` edge and at the 7 edges after it form one transmit word, MSB first. `tx_lane[1]` supplies the upper byte and `tx_lane[0]` the lower byte.
- R9: At the next `frm` edge, `dac_code` takes bits [15:2] of that transmit word. Between frame edges `dac_code` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm | input | 1 | Frame strobe, high for one cycle per word |
| adc_data | input | 12 | Parallel ADC sample |
| adc_clip_pos | input | 1 | Positive overrange strobe, valid with the sample |
| adc_clip_neg | input | 1 | Negative overrange strobe, valid with the sample |
| rx_lane | output | 2 | Receive serial lanes (1 = upper byte) |
| tx_lane | input | 2 | Transmit serial lanes (1 = upper byte) |
| dac_code | output | 14 | Parallel DAC code |

## Verification
Receive bit 7 of each byte can be read in the cycle after the frame edge. Each lower bit can be read one cycle later than the bit before it. So a complete receive word has been observed at the negative edge just before the next frame strobe. The DAC code is due one edge after the frame strobe that follows its last transmit bit, and the bench also samples it late in the frame to confirm that it stays put. To pin the 4-edge alignment delay, the bench changes the ADC inputs exactly 4 edges before each frame edge. It places decoy values one edge before and one edge after that point. All outputs are sampled on the negative clock edge, where inputs are also driven.

// File: rtl/conv_serial_link_pkg.sv
package conv_serial_link_pkg;
  localparam int unsigned ADC_W = 12;

  typedef struct packed {
    logic [ADC_W-1:0] data;
    logic             pos;
    logic             neg;
  } adc_smp_t;
endpackage

// File: rtl/csl_align.sv
module csl_align
  import conv_serial_link_pkg::*;
#(
  parameter int unsigned STAGES = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  adc_smp_t d,
  output adc_smp_t q
);
  adc_smp_t stg_q [STAGES];
  adc_smp_t stg_d [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_comb stg_d[s] = d;
    end else begin : g_rest
      always_comb stg_d[s] = stg_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_d[s];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/csl_rx_ser.sv
module csl_rx_ser
  import conv_serial_link_pkg::*;
#(
  parameter int unsigned LANES     = 2,
  parameter int unsigned LANE_BITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm,
  input  adc_smp_t         smp,
  output logic [LANES-1:0] lane
);
  localparam int unsigned WORD_W = LANES * LANE_BITS;
  localparam int unsigned PAD_W  = WORD_W - ADC_W;
  localparam logic [WORD_W-1:0] SAT_POS = {1'b0, {(WORD_W-1){1'b1}}};
  localparam logic [WORD_W-1:0] SAT_NEG = {1'b1, {(WORD_W-1){1'b0}}};

  logic [WORD_W-1:0] word;

  always_comb begin
    if (smp.pos)      word = SAT_POS;
    else if (smp.neg) word = SAT_NEG;
    else              word = {smp.data, {PAD_W{1'b0}}};
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_BITS-1:0] sr_q;
    logic [LANE_BITS-1:0] sr_d;

    always_comb begin
      if (frm) sr_d = word[l*LANE_BITS +: LANE_BITS];
      else     sr_d = {sr_q[LANE_BITS-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr_q <= '0;
      else        sr_q <= sr_d;
    end

    assign lane[l] = sr_q[LANE_BITS-1];
  end
endmodule

// File: rtl/csl_tx_des.sv
module csl_tx_des #(
  parameter int unsigned LANES     = 2,
  parameter int unsigned LANE_BITS = 8,
  localparam int unsigned WORD_W   = LANES * LANE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANES-1:0]  lane,
  output logic [WORD_W-1:0] word
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_BITS-1:0] sr_q;
    logic [LANE_BITS-1:0] sr_d;

    always_comb sr_d = {sr_q[LANE_BITS-2:0], lane[l]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr_q <= '0;
      else        sr_q <= sr_d;
    end

    assign word[l*LANE_BITS +: LANE_BITS] = sr_q;
  end
endmodule

// File: rtl/conv_serial_link.sv
module conv_serial_link
  import conv_serial_link_pkg::*;
#(
  parameter int unsigned LANES        = 2,
  parameter int unsigned LANE_BITS    = 8,
  parameter int unsigned DAC_W        = 14,
  parameter int unsigned ALIGN_STAGES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm,
  input  logic [ADC_W-1:0] adc_data,
  input  logic             adc_clip_pos,
  input  logic             adc_clip_neg,
  output logic [LANES-1:0] rx_lane,
  input  logic [LANES-1:0] tx_lane,
  output logic [DAC_W-1:0] dac_code
);
  localparam int unsigned WORD_W = LANES * LANE_BITS;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  adc_smp_t adc_in;
  adc_smp_t adc_al;

  assign adc_in = '{data: adc_data, pos: adc_clip_pos, neg: adc_clip_neg};

  csl_align #(.STAGES(ALIGN_STAGES)) u_align (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .d    (adc_in),
    .q    (adc_al)
  );

  csl_rx_ser #(.LANES(LANES), .LANE_BITS(LANE_BITS)) u_rx (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .frm  (frm),
    .smp  (adc_al),
    .lane (rx_lane)
  );

  logic [WORD_W-1:0] tx_word;

  csl_tx_des #(.LANES(LANES), .LANE_BITS(LANE_BITS)) u_tx (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .lane (tx_lane),
    .word (tx_word)
  );

  // DAC holding register, updated only at frame edges
  logic [DAC_W-1:0] dac_d;
  logic [DAC_W-1:0] dac_q;

  always_comb begin
    if (frm) dac_d = tx_word[WORD_W-1 -: DAC_W];
    else     dac_d = dac_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) dac_q <= '0;
    else             dac_q <= dac_d;
  end

  assign dac_code = dac_q;
endmodule

// File: rtl/conv_serial_link_chk.sv
module conv_serial_link_chk #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned DAC_W  = 14,
  parameter int unsigned WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frm,
  input logic              al_pos,
  input logic              al_neg,
  input logic [LANES-1:0]  rx_lane,
  input logic [WORD_W-1:0] tx_word,
  input logic [DAC_W-1:0]  dac_code
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (rx_lane == '0 && dac_code == '0));

  // R3
  clip_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm && al_pos) |=> (rx_lane[LANES-1] == 1'b0 && rx_lane[0] == 1'b1));

  // R4
  clip_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm && !al_pos && al_neg) |=> (rx_lane[LANES-1] == 1'b1 && rx_lane[0] == 1'b0));

  // R9
  dac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frm |=> $stable(dac_code));

  // R9
  dac_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm |=> (dac_code == $past(tx_word[WORD_W-1 -: DAC_W])));
endmodule

bind conv_serial_link conv_serial_link_chk #(
  .LANES (LANES),
  .DAC_W (DAC_W),
  .WORD_W(LANES * LANE_BITS)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .frm     (frm),
  .al_pos  (adc_al.pos),
  .al_neg  (adc_al.neg),
  .rx_lane (rx_lane),
  .tx_word (tx_word),
  .dac_code(dac_code)
);

// File: tb/sim_conv_serial_link.sv
module sim_conv_serial_link;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        frm;
  logic [11:0] adc_data;
  logic        adc_clip_pos;
  logic        adc_clip_neg;
  logic [1:0]  rx_lane;
  logic [1:0]  tx_lane;
  logic [13:0] dac_code;

  always #10 clk = ~clk;

  conv_serial_link u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .frm         (frm),
    .adc_data    (adc_data),
    .adc_clip_pos(adc_clip_pos),
    .adc_clip_neg(adc_clip_neg),
    .rx_lane     (rx_lane),
    .tx_lane     (tx_lane),
    .dac_code    (dac_code)
  );

  int checks = 0;
  int errors = 0;

  // vector: {adc[11:0], clip_pos, clip_neg, tx_word[15:0]}
  localparam int NV = 8;
  localparam logic [29:0] VEC [NV] = '{
    {12'hABC, 1'b0, 1'b0, 16'h1234},
    {12'h000, 1'b1, 1'b0, 16'hFFFF},
    {12'hFFF, 1'b0, 1'b1, 16'h0000},
    {12'h800, 1'b1, 1'b1, 16'hA5C3},
    {12'h7FF, 1'b0, 1'b0, 16'h8001},
    {12'h001, 1'b0, 1'b0, 16'h0003},
    {12'h5A5, 1'b0, 1'b1, 16'h5A5A},
    {12'h3C3, 1'b0, 1'b0, 16'hC3C3}
  };

  function automatic logic [15:0] exp_rx(input logic [29:0] v);
    if (v[17])      return 16'h7FFF;
    else if (v[16]) return 16'h8000;
    else            return {v[29:18], 4'h0};
  endfunction

  function automatic string rx_tag(input logic [29:0] v);
    if (v[17] && v[16]) return "R5";
    else if (v[17])     return "R3";
    else if (v[16])     return "R4";
    else                return "R2";
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [7:0]  acc_hi;
    logic [7:0]  acc_lo;
    logic [29:0] nxt;
    logic [15:0] txw;
    acc_hi = '0;
    acc_lo = '0;

    rst_n        = 1'b0;
    frm          = 1'b0;
    tx_lane      = 2'b00;
    adc_data     = VEC[0][29:18];
    adc_clip_pos = VEC[0][17];
    adc_clip_neg = VEC[0][16];
    repeat (3) @(negedge clk);
    // R1: outputs cleared during reset
    check("R1 rx_lane in reset", {14'd0, rx_lane}, 16'd0);
    check("R1 dac_code in reset", {2'd0, dac_code}, 16'd0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R1 rx_lane after release", {14'd0, rx_lane}, 16'd0);

    // table walk, one frame per vector plus a flush frame
    for (int n = 0; n < (NV + 1) * 8; n++) begin
      int i;
      int k;
      @(negedge clk);
      i = n / 8;
      k = n % 8;
      if (n > 0) begin
        acc_hi = {acc_hi[6:0], rx_lane[1]};
        acc_lo = {acc_lo[6:0], rx_lane[0]};
      end
      // R6 R7: lane order and 4-edge alignment; tag by clip case
      if (k == 0 && i > 0)
        check($sformatf("%s R6 R7 rx word vec%0d", rx_tag(VEC[i-1]), i-1),
              {acc_hi, acc_lo}, exp_rx(VEC[i-1]));
      // R8 R9: DAC loaded one edge after the frame edge
      if (k == 1 && i > 0)
        check($sformatf("R8 R9 dac load vec%0d", i-1),
              {2'd0, dac_code}, {2'd0, VEC[i-1][15:2]});
      // R9: DAC unchanged late in the frame
      if (k == 7 && i > 0 && i < NV)
        check($sformatf("R9 dac hold vec%0d", i-1),
              {2'd0, dac_code}, {2'd0, VEC[i-1][15:2]});

      frm     = (k == 0);
      txw     = (i < NV) ? VEC[i][15:0] : 16'h0000;
      tx_lane = {txw[15-k], txw[7-k]};
      nxt     = (i + 1 < NV) ? VEC[i+1] : 30'd0;
      if (k == 0 || k == 5) begin
        adc_data     = ~nxt[29:18];
        adc_clip_pos = 1'b0;
        adc_clip_neg = 1'b0;
      end else if (k == 4) begin
        adc_data     = nxt[29:18];
        adc_clip_pos = nxt[17];
        adc_clip_neg = nxt[16];
      end
    end

    // directed: full-scale sample, both lanes start high (R6)
    @(negedge clk);
    frm          = 1'b0;
    adc_data     = 12'hFFF;
    adc_clip_pos = 1'b0;
    adc_clip_neg = 1'b0;
    repeat (5) @(negedge clk);
    frm = 1'b1;
    @(negedge clk);
    frm = 1'b0;
    check("R6 directed lane msb", {14'd0, rx_lane}, 16'h0003);
    check("R9 directed dac", {2'd0, dac_code}, {2'd0, VEC[NV-1][15:2] & 14'h0}
          | {2'd0, 14'h0});

    // directed: asynchronous reset mid-frame (R1)
    tx_lane = 2'b11;
    repeat (8) @(negedge clk);
    frm = 1'b1;
    @(negedge clk);
    frm = 1'b0;
    check("R8 R9 directed ones", {2'd0, dac_code}, 16'h3FFF);
    #3 rst_n = 1'b0;
    #1;
    check("R1 async rx_lane", {14'd0, rx_lane}, 16'd0);
    check("R1 async dac_code", {2'd0, dac_code}, 16'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R1 dac after re-release", {2'd0, dac_code}, 16'd0);

    finish_run();
  end
endmodule